// File: doc/BRIEF.md
# Cabinet Command Frame Latch

This block sits behind a frame deserializer in a signal-cabinet interface unit. Its input is a stream of bytes that have already been deframed. Each byte carries a start-of-frame and an end-of-frame mark. The first byte of a frame is the station address and the second is the frame ID. The block keeps only frames addressed to its own station. It recognises two frame kinds. The first is a command frame that carries phase status. The second is a transfer frame that publishes that status on the output pins.

The command frame is 8 bytes long. From it the block takes three flag sets for each of eight phases: phase active, phase upcoming and phase check. A complete command frame only loads a staging register. The visible phase outputs change only when a transfer frame arrives, so a controller can stage its command and then release it at a time of its choosing. The block gives a one-cycle pulse each time a transfer is applied. It also keeps a sticky flag that records a transfer which arrived before any command had been staged.

Frame bit n lies in byte n/8 at bit n%8, where bit 0 is the LSB of the byte. Byte 0 is the address and byte 1 is the frame ID.

The receiver state machine has five states:
- `ST_IDLE`: waiting for a start mark.
- `ST_FRAME_ID`: the address matched and the next byte is the frame ID.
- `ST_CMD_BODY`: collecting the payload of a command frame.
- `ST_XFER_BODY`: inside a transfer frame, waiting for its end mark.
- `ST_DRAIN`: discarding bytes until an end mark.

Its transitions are:
- A byte with the start mark moves the machine to `ST_FRAME_ID` from any state when the address matches. Otherwise it moves to `ST_DRAIN`, or to `ST_IDLE` if the same byte also carries the end mark.
- `ST_FRAME_ID` moves to `ST_CMD_BODY` on ID 13.
- `ST_FRAME_ID` moves to `ST_XFER_BODY` on ID 18, or commits the transfer at once if that byte carries the end mark.
- `ST_FRAME_ID` moves to `ST_DRAIN` on any other ID.
- `ST_CMD_BODY` stages the command on an end mark at byte index 7. An end mark at any other index discards the frame. If index 7 passes without an end mark, the machine moves to `ST_DRAIN`.
- `ST_XFER_BODY` commits the transfer on its end mark.
- Every end mark without a commit returns the machine to `ST_IDLE`.

Top module: `biu_cmd_latch`

## Requirements
- R1: Frames whose address byte differs from STATION_ADDR (default 3) have no effect on staging, outputs, the pulse or the sticky flag.
- R2: A frame with ID 13 is staged only when its end mark comes on byte index 7, which makes it 8 bytes long. A shorter or longer ID 13 frame leaves the staging register unchanged.
- R3: Frame bits 24 to 31 (byte 3, bits 0 to 7) become the phase-active flags for phases 1 to 8. Output bit k of `phase_on_o` is phase k+1.
- R4: Frame bits 32 to 38 become the phase-upcoming flags for phases 1 to 7, and bit 40 (byte 5, bit 0) becomes the flag for phase 8. Bit 39 is ignored.
- R5: Frame bits 41 to 48 become the phase-check flags for phases 1 to 8.
- R6: Byte 2, bits 49 to 63 and the reserved bit 39 do not affect any output.
- R7: The outputs load the staged values only on a frame with ID 18 to this station, of 2 or more bytes. The change becomes visible in the cycle after the edge that takes that frame's end-mark byte. Staging a later command leaves the outputs unchanged until the next transfer.
- R8: `xfer_pulse_o` is high for exactly the one cycle in which a transfer first becomes visible. It is low at all other times.
- R9: `early_xfer_o` is set by a transfer that arrives while nothing has been staged since reset, and it stays set until reset.
- R10: Reset clears the staging register, the outputs, the pulse and the sticky flag.
- R11: A start mark in the middle of a frame abandons that frame. Frames with an ID other than 13 or 18, and bytes that arrive outside any frame, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid_i | input | 1 | A byte is present this cycle |
| rx_sof_i | input | 1 | The byte is the first of a frame |
| rx_eof_i | input | 1 | The byte is the last of a frame |
| rx_byte_i | input | 8 | Byte value |
| phase_on_o | output | 8 | Published phase-active flags, bit k is phase k+1 |
| phase_next_o | output | 8 | Published phase-upcoming flags |
| phase_check_o | output | 8 | Published phase-check flags |
| xfer_pulse_o | output | 1 | One-cycle pulse when a transfer is applied |
| early_xfer_o | output | 1 | Sticky: a transfer arrived before any staged command |

## Verification
The staging register cannot be seen directly, so a wrong capture index, a wrong length test or a wrong bit map stays hidden until the next transfer frame. Each check therefore stages a command, sends a transfer, and compares all 24 flags one cycle after the transfer's end mark. A receiver that is stuck in or wrongly leaves `ST_DRAIN`, or that ignores a mid-frame start mark, shows up as a missing `xfer_pulse_o` on the very next transfer. A command that changes the outputs early shows up as soon as the outputs are sampled before the transfer.

// File: rtl/biu_cmd_pkg.sv
package biu_cmd_pkg;

    localparam int PHASES = 8;

    // capture window: bytes 3..6 hold every decoded bit
    localparam int CAP_FIRST_BYTE = 3;
    localparam int CAP_BYTES      = 4;
    localparam int CAP_BASE_BIT   = CAP_FIRST_BYTE * 8;

    // absolute frame bit positions
    localparam int POS_ON_FIRST    = 24;
    localparam int POS_NEXT_FIRST  = 32;
    localparam int POS_NEXT_LAST   = 40;
    localparam int POS_CHECK_FIRST = 41;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FRAME_ID,
        ST_CMD_BODY,
        ST_XFER_BODY,
        ST_DRAIN
    } rx_state_e;

    typedef struct packed {
        logic [PHASES-1:0] check;
        logic [PHASES-1:0] next;
        logic [PHASES-1:0] on;
    } phase_word_t;

endpackage

// File: rtl/biu_frame_rx.sv
module biu_frame_rx
    import biu_cmd_pkg::*;
#(
    parameter logic [7:0] STATION_ADDR = 8'h03,
    parameter logic [7:0] CMD_ID       = 8'h0D,
    parameter logic [7:0] XFER_ID      = 8'h12,
    parameter int         CMD_LEN      = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_valid_i,
    input  logic                   rx_sof_i,
    input  logic                   rx_eof_i,
    input  logic [7:0]             rx_byte_i,
    output logic [CAP_BYTES*8-1:0] cap_bits_o,
    output logic                   stage_commit_o,
    output logic                   xfer_commit_o
);

    localparam int IDX_W = $clog2(CMD_LEN + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CMD_LEN - 1);
    localparam logic [IDX_W-1:0] IDX_SAT  = IDX_W'(CMD_LEN);

    rx_state_e        state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [CAP_BYTES*8-1:0] cap_q;
    logic             mid_byte;

    assign mid_byte = rx_valid_i && !rx_sof_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and commit strobes
    always_comb begin
        state_d        = state_q;
        stage_commit_o = 1'b0;
        xfer_commit_o  = 1'b0;
        if (rx_valid_i && rx_sof_i) begin
            if (rx_eof_i) begin
                state_d = ST_IDLE;
            end else if (rx_byte_i == STATION_ADDR) begin
                state_d = ST_FRAME_ID;
            end else begin
                state_d = ST_DRAIN;
            end
        end else if (rx_valid_i) begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_FRAME_ID: begin
                    if (rx_byte_i == CMD_ID) begin
                        state_d = rx_eof_i ? ST_IDLE : ST_CMD_BODY;
                    end else if (rx_byte_i == XFER_ID) begin
                        state_d       = rx_eof_i ? ST_IDLE : ST_XFER_BODY;
                        xfer_commit_o = rx_eof_i;
                    end else begin
                        state_d = rx_eof_i ? ST_IDLE : ST_DRAIN;
                    end
                end
                ST_CMD_BODY: begin
                    if (rx_eof_i) begin
                        state_d        = ST_IDLE;
                        stage_commit_o = (idx_q == LAST_IDX);
                    end else if (idx_q == LAST_IDX) begin
                        state_d = ST_DRAIN;
                    end
                end
                ST_XFER_BODY: begin
                    if (rx_eof_i) begin
                        state_d       = ST_IDLE;
                        xfer_commit_o = 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (rx_eof_i) begin
                        state_d = ST_IDLE;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // byte index of the next byte in the frame, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (rx_valid_i && rx_sof_i) begin
            idx_q <= IDX_W'(1);
        end else if (rx_valid_i && idx_q < IDX_SAT) begin
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    // payload capture, one lane per byte of the window
    for (genvar g = 0; g < CAP_BYTES; g++) begin : g_cap
        localparam logic [IDX_W-1:0] LANE_IDX = IDX_W'(CAP_FIRST_BYTE + g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cap_q[g*8 +: 8] <= '0;
            end else if (mid_byte && state_q == ST_CMD_BODY && idx_q == LANE_IDX) begin
                cap_q[g*8 +: 8] <= rx_byte_i;
            end
        end
    end

    assign cap_bits_o = cap_q;

    AST_STAGE_ON_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        stage_commit_o |-> (rx_valid_i && rx_eof_i && !rx_sof_i)) else $error("stage without end mark"); // R2
    AST_XFER_ON_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_commit_o |-> (rx_valid_i && rx_eof_i && !rx_sof_i)) else $error("transfer without end mark"); // R7
    AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stage_commit_o, xfer_commit_o})) else $error("two commits at once"); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE || state_q == ST_DRAIN) |-> !(stage_commit_o || xfer_commit_o)) else $error("commit outside frame"); // R11

endmodule

// File: rtl/biu_phase_map.sv
module biu_phase_map
    import biu_cmd_pkg::*;
(
    input  logic [CAP_BYTES*8-1:0] cap_bits_i,
    output phase_word_t            word_o
);

    // reserved and input-only bits of the window carry no command
    logic unused_window;
    assign unused_window = ^{cap_bits_i[POS_NEXT_FIRST + PHASES - 1 - CAP_BASE_BIT],
                             cap_bits_i[CAP_BYTES*8-1 : POS_CHECK_FIRST + PHASES - CAP_BASE_BIT]};

    for (genvar p = 0; p < PHASES; p++) begin : g_phase
        assign word_o.on[p]    = cap_bits_i[POS_ON_FIRST + p - CAP_BASE_BIT];
        assign word_o.check[p] = cap_bits_i[POS_CHECK_FIRST + p - CAP_BASE_BIT];
        if (p < PHASES - 1) begin : g_next_low
            assign word_o.next[p] = cap_bits_i[POS_NEXT_FIRST + p - CAP_BASE_BIT];
        end else begin : g_next_top
            assign word_o.next[p] = cap_bits_i[POS_NEXT_LAST - CAP_BASE_BIT];
        end
    end

endmodule

// File: rtl/biu_out_stage.sv
module biu_out_stage
    import biu_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  phase_word_t word_i,
    input  logic        stage_commit_i,
    input  logic        xfer_commit_i,
    output phase_word_t out_o,
    output logic        xfer_pulse_o,
    output logic        early_xfer_o
);

    phase_word_t stage_q;
    phase_word_t out_q;
    logic        staged_any_q;
    logic        pulse_q;
    logic        early_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q      <= '0;
            staged_any_q <= 1'b0;
        end else if (stage_commit_i) begin
            stage_q      <= word_i;
            staged_any_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q   <= '0;
            pulse_q <= 1'b0;
            early_q <= 1'b0;
        end else begin
            pulse_q <= xfer_commit_i;
            if (xfer_commit_i) begin
                out_q <= stage_q;
                if (!staged_any_q) begin
                    early_q <= 1'b1;
                end
            end
        end
    end

    assign out_o        = out_q;
    assign xfer_pulse_o = pulse_q;
    assign early_xfer_o = early_q;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_commit_i |=> $stable(out_q)) else $error("outputs moved without transfer"); // R7
    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !stage_commit_i |=> $stable(stage_q)) else $error("staging moved without command"); // R2
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q) else $error("pulse longer than one cycle"); // R8
    AST_EARLY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        early_q |=> early_q) else $error("sticky flag dropped"); // R9

endmodule

// File: rtl/biu_cmd_latch.sv
module biu_cmd_latch
    import biu_cmd_pkg::*;
#(
    parameter logic [7:0] STATION_ADDR = 8'h03,
    parameter logic [7:0] CMD_ID       = 8'h0D,
    parameter logic [7:0] XFER_ID      = 8'h12,
    parameter int         CMD_LEN      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid_i,
    input  logic              rx_sof_i,
    input  logic              rx_eof_i,
    input  logic [7:0]        rx_byte_i,
    output logic [PHASES-1:0] phase_on_o,
    output logic [PHASES-1:0] phase_next_o,
    output logic [PHASES-1:0] phase_check_o,
    output logic              xfer_pulse_o,
    output logic              early_xfer_o
);

    logic [CAP_BYTES*8-1:0] cap_bits;
    logic                   stage_commit;
    logic                   xfer_commit;
    phase_word_t            decoded;
    phase_word_t            published;

    biu_frame_rx #(
        .STATION_ADDR (STATION_ADDR),
        .CMD_ID       (CMD_ID),
        .XFER_ID      (XFER_ID),
        .CMD_LEN      (CMD_LEN)
    ) rx_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_valid_i     (rx_valid_i),
        .rx_sof_i       (rx_sof_i),
        .rx_eof_i       (rx_eof_i),
        .rx_byte_i      (rx_byte_i),
        .cap_bits_o     (cap_bits),
        .stage_commit_o (stage_commit),
        .xfer_commit_o  (xfer_commit)
    );

    biu_phase_map map_i (
        .cap_bits_i (cap_bits),
        .word_o     (decoded)
    );

    biu_out_stage stage_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .word_i         (decoded),
        .stage_commit_i (stage_commit),
        .xfer_commit_i  (xfer_commit),
        .out_o          (published),
        .xfer_pulse_o   (xfer_pulse_o),
        .early_xfer_o   (early_xfer_o)
    );

    assign phase_on_o    = published.on;
    assign phase_next_o  = published.next;
    assign phase_check_o = published.check;

endmodule

// File: tb/biu_cmd_latch_tb.sv
module biu_cmd_latch_tb_top;

    localparam time CLK_PERIOD = 10ns;

    typedef logic [7:0] frm_t [12];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid_i = 1'b0;
    logic       rx_sof_i = 1'b0;
    logic       rx_eof_i = 1'b0;
    logic [7:0] rx_byte_i = 8'h00;
    logic [7:0] phase_on_o, phase_next_o, phase_check_o;
    logic       xfer_pulse_o, early_xfer_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    biu_cmd_latch dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_valid_i    (rx_valid_i),
        .rx_sof_i      (rx_sof_i),
        .rx_eof_i      (rx_eof_i),
        .rx_byte_i     (rx_byte_i),
        .phase_on_o    (phase_on_o),
        .phase_next_o  (phase_next_o),
        .phase_check_o (phase_check_o),
        .xfer_pulse_o  (xfer_pulse_o),
        .early_xfer_o  (early_xfer_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_outs(input string tag, input logic [7:0] on, input logic [7:0] nx, input logic [7:0] ck);
        check(tag, {8'h00, phase_check_o, phase_next_o, phase_on_o}, {8'h00, ck, nx, on});
    endtask

    function automatic frm_t mk_cmd(input logic [7:0] addr, input logic [7:0] on,
                                    input logic [7:0] nx, input logic [7:0] ck, input bit junk);
        frm_t f;
        for (int i = 0; i < 12; i++) f[i] = 8'h00;
        f[0] = addr;
        f[1] = 8'h0D;
        f[2] = junk ? 8'hFF : 8'h00;
        for (int p = 0; p < 8; p++) begin
            int pn;
            f[(24 + p) / 8][(24 + p) % 8] = on[p];
            pn = (p < 7) ? 32 + p : 40;
            f[pn / 8][pn % 8] = nx[p];
            f[(41 + p) / 8][(41 + p) % 8] = ck[p];
        end
        if (junk) begin
            f[4][7] = 1'b1;
            for (int n = 49; n < 64; n++) f[n / 8][n % 8] = 1'b1;
            f[8] = 8'hFF;
        end
        return f;
    endfunction

    function automatic frm_t mk_hdr(input logic [7:0] addr, input logic [7:0] id);
        frm_t f;
        for (int i = 0; i < 12; i++) f[i] = 8'h5A;
        f[0] = addr;
        f[1] = id;
        return f;
    endfunction

    // drives n bytes at falling edges; returns at the falling edge after the last byte
    task automatic send(input frm_t f, input int n, input bit close);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid_i = 1'b1;
            rx_sof_i   = (i == 0);
            rx_eof_i   = close && (i == n - 1);
            rx_byte_i  = f[i];
        end
        @(negedge clk);
        rx_valid_i = 1'b0;
        rx_sof_i   = 1'b0;
        rx_eof_i   = 1'b0;
    endtask

    task automatic xfer_and_check(input string tag, input logic [7:0] addr, input int n,
                                  input bit exp_pulse, input logic [7:0] on,
                                  input logic [7:0] nx, input logic [7:0] ck);
        send(mk_hdr(addr, 8'h12), n, 1'b1);
        check({tag, " pulse R8"}, 32'(xfer_pulse_o), 32'(exp_pulse));
        check_outs(tag, on, nx, ck);
        @(negedge clk);
        check({tag, " pulse drop R8"}, 32'(xfer_pulse_o), 32'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check_outs("R10 reset outputs", 8'h00, 8'h00, 8'h00);
        check("R10 reset pulse", 32'(xfer_pulse_o), 32'd0);
        check("R10 reset sticky", 32'(early_xfer_o), 32'd0);
    endtask

    task automatic t_early();
        xfer_and_check("R9 early transfer", 8'h03, 2, 1'b1, 8'h00, 8'h00, 8'h00);
        check("R9 sticky set", 32'(early_xfer_o), 32'd1);
    endtask

    task automatic t_basic();
        send(mk_cmd(8'h03, 8'hA5, 8'h3C, 8'h81, 1'b0), 8, 1'b1);
        repeat (3) @(negedge clk);
        check_outs("R7 staged not visible", 8'h00, 8'h00, 8'h00);
        xfer_and_check("R3 R4 R5 R7 basic map", 8'h03, 2, 1'b1, 8'hA5, 8'h3C, 8'h81);
        check("R9 sticky stays", 32'(early_xfer_o), 32'd1);
    endtask

    task automatic t_ignored();
        send(mk_cmd(8'h03, 8'h0F, 8'h80, 8'h7E, 1'b1), 8, 1'b1);
        xfer_and_check("R4 R6 ignored bits", 8'h03, 2, 1'b1, 8'h0F, 8'h80, 8'h7E);
        send(mk_cmd(8'h03, 8'h00, 8'h00, 8'h00, 1'b1), 8, 1'b1);
        xfer_and_check("R6 junk only", 8'h03, 2, 1'b1, 8'h00, 8'h00, 8'h00);
        send(mk_cmd(8'h03, 8'h0F, 8'h80, 8'h7E, 1'b0), 8, 1'b1);
        xfer_and_check("R3 restore", 8'h03, 2, 1'b1, 8'h0F, 8'h80, 8'h7E);
    endtask

    task automatic t_addr();
        send(mk_cmd(8'h04, 8'hFF, 8'hFF, 8'hFF, 1'b0), 8, 1'b1);
        xfer_and_check("R1 foreign command", 8'h03, 2, 1'b1, 8'h0F, 8'h80, 8'h7E);
        send(mk_cmd(8'h03, 8'h11, 8'h22, 8'h44, 1'b0), 8, 1'b1);
        xfer_and_check("R1 foreign transfer", 8'h05, 2, 1'b0, 8'h0F, 8'h80, 8'h7E);
    endtask

    task automatic t_len();
        frm_t f;
        f = mk_cmd(8'h03, 8'hC3, 8'hC3, 8'hC3, 1'b0);
        send(f, 7, 1'b1);
        send(f, 9, 1'b1);
        xfer_and_check("R2 bad lengths", 8'h03, 3, 1'b1, 8'h11, 8'h22, 8'h44);
    endtask

    task automatic t_other_id();
        frm_t f;
        f = mk_cmd(8'h03, 8'h99, 8'h99, 8'h99, 1'b0);
        f[1] = 8'h0E;
        send(f, 8, 1'b1);
        send(mk_cmd(8'h03, 8'h99, 8'h99, 8'h99, 1'b0), 3, 1'b0);
        xfer_and_check("R11 other id and abort", 8'h03, 2, 1'b1, 8'h11, 8'h22, 8'h44);
        @(negedge clk);
        rx_valid_i = 1'b1;
        rx_eof_i   = 1'b1;
        rx_byte_i  = 8'h12;
        @(negedge clk);
        rx_valid_i = 1'b0;
        rx_eof_i   = 1'b0;
        check("R11 stray byte no pulse", 32'(xfer_pulse_o), 32'd0);
    endtask

    task automatic t_hold();
        send(mk_cmd(8'h03, 8'h5A, 8'hA5, 8'h0F, 1'b0), 8, 1'b1);
        repeat (5) @(negedge clk);
        check_outs("R7 hold until transfer", 8'h11, 8'h22, 8'h44);
        xfer_and_check("R7 long transfer frame", 8'h03, 4, 1'b1, 8'h5A, 8'hA5, 8'h0F);
    endtask

    task automatic t_reset_mid();
        send(mk_cmd(8'h03, 8'hFF, 8'h01, 8'h02, 1'b0), 8, 1'b1);
        do_reset();
        check_outs("R10 outputs cleared", 8'h00, 8'h00, 8'h00);
        check("R10 sticky cleared", 32'(early_xfer_o), 32'd0);
        xfer_and_check("R10 staging cleared", 8'h03, 2, 1'b1, 8'h00, 8'h00, 8'h00);
        check("R9 sticky after reset", 32'(early_xfer_o), 32'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_early();
        t_basic();
        t_ignored();
        t_addr();
        t_len();
        t_other_id();
        t_hold();
        t_reset_mid();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule